// File: doc/BRIEF.md
# Page Translation Cache with Process Tags

This block is a small set-associative cache of address translations. A request presents a virtual address. The block splits the virtual page number into a set index and a tag, and compares the tag against every way of the chosen set in the same cycle. On a hit it returns the physical address: the cached physical page number with the page offset appended unchanged. On a miss it raises a miss flag. An external table walker then supplies the missing mapping on the fill port, and the block writes it into the indexed set. If the set has a free way, the fill uses the lowest free way; if the set is full, a per-set rotating pointer picks the way to overwrite.

A context switch is signalled by a write of the translation base register, which also carries the incoming process number. The `tag_mode` input selects one of two ways to keep translations from different processes apart.
- **Flush mode:** every such write discards every entry, and the process number plays no part in lookups.
- **Tagged mode:** each entry records the process that filled it, and a lookup only matches entries of the running process. A switch may also discard the entries of the process being switched out, and only those.

Top module: `page_xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss, and the running process number is 0.
- R2: The virtual page number is `lk_va[13:6]`. The set index is its low 2 bits and the tag is its upper 6 bits. A hit needs a valid entry in the selected set with an equal tag; an equal tag in another set, or another tag in the same set, misses.
- R3: `lk_hit` and `lk_miss` are both 0 when `lk_valid` is 0, and exactly one of them is 1 when it is 1. `lk_pa` is `{ppn, lk_va[5:0]}` on a hit and 0 otherwise.
- R4: A fill on one clock edge is visible to a lookup in the very next cycle.
- R5: A fill into a set that has invalid ways uses the lowest-numbered invalid way, so no valid entry is lost while a free way exists.
- R6: A fill into a full set overwrites the way named by that set's rotating pointer and then advances the pointer. The pointer starts at way 0 after reset, so a fifth distinct fill into an empty set evicts the first one and a sixth evicts the second.
- R7: With `tag_mode`=0, a `ctx_wr` invalidates every entry.
- R8: With `tag_mode`=1, each fill records the running process number, and a lookup only hits an entry whose recorded number equals the running one.
- R9: With `tag_mode`=1, a `ctx_wr` with `ctx_inv`=1 invalidates exactly the entries of the outgoing (running) process; other processes' entries survive and hit again once their process is running. With `ctx_inv`=0 no entry is removed. In both cases `ctx_pid` becomes the running process.
- R10: When `ctx_wr` and `fill_valid` are both asserted in the same cycle, the fill is dropped.
- R11: With `tag_mode`=0, the process number is ignored in lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_mode | input | 1 | 0: flush on context switch; 1: process-tagged entries |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 14 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found no translation |
| lk_pa | output | 12 | Physical address on a hit, 0 otherwise |
| fill_valid | input | 1 | Write a new translation |
| fill_vpn | input | 8 | Virtual page number of the fill |
| fill_ppn | input | 6 | Physical page number of the fill |
| ctx_wr | input | 1 | Base register write (context switch) |
| ctx_pid | input | 4 | Incoming process number |
| ctx_inv | input | 1 | In tagged mode, drop the outgoing process's entries |

## Verification
The bench fills one set to capacity and beyond, then checks which entry disappeared. A design that ignored the free ways, or that started its rotating pointer elsewhere, would evict the wrong translation or a still-needed one. It probes a matching tag placed in a neighbouring set and a different tag in the right set, which a wrong split of the page number would turn into false hits. It also raises a switch together with a fill, where a wrong priority leaves a stale entry live.

In tagged mode the bench switches between processes with and without the drop flag. A design that compared no process number would return another process's frame. One that invalidated too broadly would lose a translation that must come back on return. Finally it drops back to flush mode with a different process running, where a design that kept comparing process numbers would miss.

// File: rtl/page_xlate_cache.sv
module page_xlate_cache #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SET_W = 2,
  parameter int WAY_W = 2,
  parameter int PID_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tag_mode,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_va,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic [PA_W-1:0]     lk_pa,
  input  logic                fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                ctx_wr,
  input  logic [PID_W-1:0]    ctx_pid,
  input  logic                ctx_inv
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 1 << WAY_W;
  localparam int IDX_W = SET_W + WAY_W;
  localparam int N     = SETS * WAYS;

  logic [N-1:0]                vld;
  logic [N-1:0][TAG_W-1:0]     tag_q;
  logic [N-1:0][PPN_W-1:0]     ppn_q;
  logic [N-1:0][PID_W-1:0]     pid_q;
  logic [SETS-1:0][WAY_W-1:0]  rr_q;
  logic [PID_W-1:0]            cur_pid;

  logic [N-1:0] match, own;

  wire [VPN_W-1:0] lk_vpn = lk_va[VA_W-1:OFF_W];
  wire [SET_W-1:0] lk_set = lk_vpn[SET_W-1:0];
  wire [TAG_W-1:0] lk_tag = lk_vpn[VPN_W-1:SET_W];

  for (genvar e = 0; e < N; e++) begin : g_ent
    assign match[e] = vld[e] && (tag_q[e] == lk_tag) && (!tag_mode || pid_q[e] == cur_pid);
    assign own[e]   = vld[e] && (pid_q[e] == cur_pid);
  end

  logic             any_hit;
  logic [PPN_W-1:0] hit_ppn;
  always_comb begin
    any_hit = 1'b0;
    hit_ppn = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[{lk_set, WAY_W'(w)}]) begin
        any_hit = 1'b1;
        hit_ppn = ppn_q[{lk_set, WAY_W'(w)}];
      end
    end
  end

  assign lk_hit  = lk_valid && any_hit;
  assign lk_miss = lk_valid && !any_hit;
  assign lk_pa   = lk_hit ? {hit_ppn, lk_va[OFF_W-1:0]} : '0;

  wire [SET_W-1:0] f_set = fill_vpn[SET_W-1:0];
  wire [TAG_W-1:0] f_tag = fill_vpn[VPN_W-1:SET_W];
  logic             has_free;
  logic [WAY_W-1:0] free_way;
  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[{f_set, WAY_W'(w)}]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  wire [WAY_W-1:0] f_way  = has_free ? free_way : rr_q[f_set];
  wire [IDX_W-1:0] f_idx  = {f_set, f_way};
  wire             f_take = fill_valid && !ctx_wr;
  wire [N-1:0]     kill   = tag_mode ? (ctx_inv ? own : '0) : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      rr_q    <= '0;
      cur_pid <= '0;
    end else if (ctx_wr) begin
      vld     <= vld & ~kill;
      cur_pid <= ctx_pid;
    end else if (fill_valid) begin
      vld[f_idx] <= 1'b1;
      if (!has_free) rr_q[f_set] <= rr_q[f_set] + WAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (f_take) begin
      tag_q[f_idx] <= f_tag;
      ppn_q[f_idx] <= fill_ppn;
      pid_q[f_idx] <= cur_pid;
    end
  end

  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));

  a_r4_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !ctx_wr) |=> (vld[$past(f_idx)] && tag_q[$past(f_idx)] == $past(f_tag)));

  a_r7_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_wr && !tag_mode) |=> (vld == '0));

  a_r9_outgoing_gone: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_wr && tag_mode && ctx_inv && ctx_pid == cur_pid) |=> (own == '0));

  a_r10_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_wr |=> ($countones(vld) <= $past($countones(vld))));
endmodule

// File: tb/tb_page_xlate_cache.sv
module tb_page_xlate_cache;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tag_mode = 0;
  logic        lk_valid = 0;
  logic [13:0] lk_va = '0;
  logic        lk_hit, lk_miss;
  logic [11:0] lk_pa;
  logic        fill_valid = 0;
  logic [7:0]  fill_vpn = '0;
  logic [5:0]  fill_ppn = '0;
  logic        ctx_wr = 0;
  logic [3:0]  ctx_pid = '0;
  logic        ctx_inv = 0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  page_xlate_cache dut (
    .clk(clk), .rst_n(rst_n), .tag_mode(tag_mode),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .ctx_wr(ctx_wr), .ctx_pid(ctx_pid), .ctx_inv(ctx_inv)
  );

  typedef struct packed {
    logic       is_fill;
    logic [7:0] vpn;
    logic [5:0] off;
    logic [5:0] ppn;
    logic       hit;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h0D, 6'h15, 6'h00, 1'b0},
    '{1'b1, 8'h0D, 6'h00, 6'h2D, 1'b0},
    '{1'b0, 8'h0D, 6'h15, 6'h2D, 1'b1},
    '{1'b0, 8'h0D, 6'h3F, 6'h2D, 1'b1},
    '{1'b0, 8'h1D, 6'h00, 6'h00, 1'b0},
    '{1'b0, 8'h0C, 6'h00, 6'h00, 1'b0},
    '{1'b1, 8'h02, 6'h00, 6'h33, 1'b0},
    '{1'b0, 8'h02, 6'h01, 6'h33, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [7:0] vpn, input logic [5:0] off, input bit hit,
                      input logic [5:0] ppn, input string req);
    logic [11:0] epa;
    epa = hit ? {ppn, off} : 12'h000;
    lk_valid = 1;
    lk_va = {vpn, off};
    #1;
    chk(lk_hit == hit && lk_miss == !hit, req, {14'h0, lk_hit, lk_miss}, {14'h0, hit, !hit});
    chk(lk_pa == epa, req, {4'h0, lk_pa}, {4'h0, epa});
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn);
    fill_valid = 1;
    fill_vpn = vpn;
    fill_ppn = ppn;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic ctx(input logic [3:0] pid, input bit inv);
    ctx_wr = 1;
    ctx_pid = pid;
    ctx_inv = inv;
    @(negedge clk);
    ctx_wr = 0;
    ctx_inv = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R3: idle port reports neither outcome
    chk(!lk_hit && !lk_miss && lk_pa == 0, "R3", {3'h0, lk_hit, lk_miss, lk_pa}, 16'h0);
    @(negedge clk);
    // R1: nothing valid after reset
    look(8'h0D, 6'h15, 0, 6'h00, "R1");
    look(8'hFF, 6'h3F, 0, 6'h00, "R1");

    // R2 R3 R4 via table
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].is_fill) fill(TBL[i].vpn, TBL[i].ppn);
      else look(TBL[i].vpn, TBL[i].off, TBL[i].hit, TBL[i].ppn, "R2_R3_R4");
    end

    // R7: flush mode switch clears all
    ctx(4'h0, 0);
    look(8'h0D, 6'h15, 0, 6'h00, "R7");
    look(8'h02, 6'h01, 0, 6'h00, "R7");

    // R10: switch with simultaneous fill drops the fill
    fill_valid = 1; fill_vpn = 8'h20; fill_ppn = 6'h01;
    ctx_wr = 1; ctx_pid = 4'h0;
    @(negedge clk);
    fill_valid = 0; ctx_wr = 0;
    look(8'h20, 6'h00, 0, 6'h00, "R10");

    // R5: four fills into empty set 3 all survive
    for (int t = 1; t <= 4; t++) fill({6'(t), 2'b11}, 6'(10 + t));
    for (int t = 1; t <= 4; t++) look({6'(t), 2'b11}, 6'h07, 1, 6'(10 + t), "R5");
    // R6: fifth evicts first, sixth evicts second
    fill({6'd5, 2'b11}, 6'd15);
    look({6'd1, 2'b11}, 6'h00, 0, 6'h00, "R6");
    for (int t = 2; t <= 5; t++) look({6'(t), 2'b11}, 6'h00, 1, 6'(10 + t), "R6");
    fill({6'd6, 2'b11}, 6'd16);
    look({6'd2, 2'b11}, 6'h00, 0, 6'h00, "R6");
    look({6'd6, 2'b11}, 6'h00, 1, 6'd16, "R6");
    look({6'd3, 2'b11}, 6'h00, 1, 6'd13, "R6");

    // R8: tagged mode, process number must match
    tag_mode = 1;
    ctx(4'h1, 0);
    look({6'd3, 2'b11}, 6'h00, 0, 6'h00, "R8");
    fill(8'h05, 6'h10);
    look(8'h05, 6'h02, 1, 6'h10, "R8");
    ctx(4'h2, 0);
    look(8'h05, 6'h02, 0, 6'h00, "R8");
    fill(8'h05, 6'h20);
    look(8'h05, 6'h02, 1, 6'h20, "R8");

    // R9: drop only outgoing process entries
    ctx(4'h1, 1);
    look(8'h05, 6'h02, 1, 6'h10, "R9");
    ctx(4'h2, 0);
    look(8'h05, 6'h02, 0, 6'h00, "R9");
    ctx(4'h0, 0);
    look({6'd3, 2'b11}, 6'h09, 1, 6'd13, "R9");
    look({6'd6, 2'b11}, 6'h09, 1, 6'd16, "R9");

    // R11: flush mode ignores process number
    ctx(4'h2, 0);
    tag_mode = 0;
    look(8'h05, 6'h02, 1, 6'h10, "R11");
    look({6'd4, 2'b11}, 6'h01, 1, 6'd14, "R11");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule